// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit logical address into a physical address in two steps. The top four bits pick one of sixteen segment registers. Each register holds a byte address where that segment's page table starts, a page limit, and separate read and write permission bits. The next eight bits are the page index. It is checked against the limit and against the permission that the access needs. Only when both checks pass does the block read a two-byte page table entry from memory. It then joins the 12-bit frame number in that entry to the unchanged 12-bit offset.

A requester hands over one address at a time with a valid/ready handshake and gets back a one-cycle response. The response carries the physical address, a fault flag and a fault cause. Software programs segment registers through a simple write port, and a write takes effect on the next lookup. Two segments may name the same table start address, and they then map their pages onto the same frames. The memory read port has a fixed latency of one cycle: data returned in the cycle after a read request is used.

Top module: `seg_xlate_top`

## Requirements
- R1: Address bits [23:20] select the segment, bits [19:12] are the page index and bits [11:0] are the offset. A successful response carries the physical address {frame, offset}, with the offset unchanged.
- R2: After reset all sixteen segments have limit 0 and no permissions. Any access then faults: page 0 faults with the permission cause (1) and a page above 0 faults with the bounds cause (0).
- R3: A page index strictly greater than the segment's limit faults with cause 0 (bounds) and issues no memory read. A page index equal to the limit is allowed.
- R4: A write to a segment whose write bit is clear faults with cause 1 (permission), and so does a read from a segment whose read bit is clear. Neither case issues a memory read.
- R5: When an access breaks both the limit and the permission, the reported cause is bounds (0).
- R6: A permitted access issues exactly one memory read, at address table_start + 2 × page. The frame is bits [11:0] of the returned 16-bit entry, and bits [15:12] are ignored.
- R7: req_ready is high only while the block is idle. Each accepted request (req_valid and req_ready at a clock edge) produces exactly one rsp_valid pulse, one cycle long.
- R8: A faulting request responds in the second cycle after the accepting edge. A permitted request responds in the third cycle after that edge.
- R9: Two segments programmed with the same table start address give the same frame for the same page index.
- R10: A register write (cfg_we) replaces the whole entry selected by cfg_idx for all later requests. A faulting response drives rsp_paddr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_idx | input | 4 | Segment register to write |
| cfg_pt_base | input | 24 | Byte address of the segment's page table |
| cfg_limit | input | 8 | Highest page index allowed |
| cfg_rd_ok | input | 1 | Read permission |
| cfg_wr_ok | input | 1 | Write permission |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 24 | Logical address |
| req_is_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_en | output | 1 | Page table entry read strobe |
| mem_rd_addr | output | 24 | Byte address of the entry |
| mem_rd_data | input | 16 | Entry data, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |
| rsp_err | output | 1 | Fault flag |
| rsp_cause | output | 1 | 0 = bounds, 1 = permission |

## Verification
The assertions check the following on every cycle:
- the handshake: ready only when idle, and a response pulse that lasts one cycle;
- that no memory read is made ahead of a fault, and that exactly one read is made ahead of a success;
- the two response latencies;
- that the offset is kept;
- that a faulting address reads zero.

Only the bench's scenarios can show the following:
- the actual translation values and the entry address arithmetic;
- which cause wins when an access breaks both the limit and the permission;
- the limit edge case (page equal to the limit);
- the reset state of the register bank;
- page sharing between segments;
- reprogramming of a segment between requests.

// File: rtl/seg_xlate_pkg.sv
// Package: shared enums for the segmented paging translator.
// Assumes: one-bit fault cause, four-state request walker.
package seg_xlate_pkg;

    // Fault cause reported on a failed translation
    typedef enum logic {
        CAUSE_BOUNDS = 1'b0,
        CAUSE_PERM   = 1'b1
    } xl_cause_e;

    // Request walker states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RESP   = 2'd3
    } xl_state_e;

endpackage

// File: rtl/seg_xlate_segtab.sv
// Module: segment register bank.
// Holds one table start address, page limit and read/write permission
// bit per segment. All entries reset to the unused state (limit 0, no
// permissions). A write replaces a whole entry. The read port is
// combinational on the selected index.
module seg_xlate_segtab #(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int PA_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [PAGE_W-1:0] wr_limit,
    input  logic              wr_rd_ok,
    input  logic              wr_wr_ok,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [PA_W-1:0]   rd_base,
    output logic [PAGE_W-1:0] rd_limit,
    output logic              rd_rd_ok,
    output logic              rd_wr_ok
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]   base_q  [NSEG];
    logic [PAGE_W-1:0] limit_q [NSEG];
    logic [NSEG-1:0]   rok_q;
    logic [NSEG-1:0]   wok_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        // Per-entry register: clear on reset, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                rok_q[g]   <= 1'b0;
                wok_q[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                rok_q[g]   <= wr_rd_ok;
                wok_q[g]   <= wr_wr_ok;
            end
        end
    end

    // Read mux for the segment under lookup
    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = limit_q[rd_idx];
        rd_rd_ok = rok_q[rd_idx];
        rd_wr_ok = wok_q[rd_idx];
    end

endmodule

// File: rtl/seg_xlate_guard.sv
// Module: limit and permission guard plus entry address generator.
// Purely combinational. A limit violation takes priority over a
// permission violation when both apply. The entry address is the
// table start plus the page index scaled by the entry size in bytes.
// Assumes: the entry size is a power of two in bytes.
module seg_xlate_guard
    import seg_xlate_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int PA_W   = 24,
    parameter int PTE_W  = 16
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    input  logic [PA_W-1:0]   base,
    input  logic [PAGE_W-1:0] limit,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output logic              fault,
    output xl_cause_e         cause,
    output logic [PA_W-1:0]   pte_addr
);
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);

    logic over_limit;
    logic no_perm;

    // Classify the access against the segment entry
    always_comb begin
        over_limit = (page > limit);
        no_perm    = is_write ? !wr_ok : !rd_ok;
        fault      = over_limit || no_perm;
        cause      = over_limit ? CAUSE_BOUNDS : CAUSE_PERM;
    end

    // Entry byte address inside the segment's page table
    always_comb begin
        pte_addr = base + (PA_W'(page) << PTE_SHIFT);
    end

endmodule

// File: rtl/seg_xlate_walker.sv
// Module: request walker.
// Accepts one request when idle and latches it. In the lookup cycle it
// either ends with a fault or issues a single entry read. One cycle
// later it joins the returned frame to the offset. It then presents the
// response for one cycle.
// Assumes: read data arrives exactly one cycle after mem_rd_en.
module seg_xlate_walker
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 24,
    parameter int PTE_W  = 16,
    parameter int PFN_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
    input  logic                   req_is_write,
    output logic [SEG_W-1:0]       cur_seg,
    output logic [PAGE_W-1:0]      cur_page,
    output logic                   cur_write,
    input  logic                   fault,
    input  xl_cause_e              cause,
    input  logic [PA_W-1:0]        pte_addr,
    output logic                   mem_rd_en,
    output logic [PA_W-1:0]        mem_rd_addr,
    input  logic [PTE_W-1:0]       mem_rd_data,
    output logic                   rsp_valid,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   rsp_err,
    output logic                   rsp_cause
);
    localparam int VA_W = SEG_W + PAGE_W + OFF_W;

    xl_state_e               state_q;
    logic [VA_W-1:0]         va_q;
    logic                    wr_q;
    logic [PFN_W+OFF_W-1:0]  paddr_q;
    logic                    err_q;
    xl_cause_e               cause_q;
    logic                    accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // State sequencing: idle -> lookup -> (wait) -> response -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (accept) state_q <= ST_LOOKUP;
                ST_LOOKUP: state_q <= fault ? ST_RESP : ST_WAIT;
                ST_WAIT:   state_q <= ST_RESP;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q <= '0;
            wr_q <= 1'b0;
        end else if (accept) begin
            va_q <= req_vaddr;
            wr_q <= req_is_write;
        end
    end

    // Response result: fault in lookup, or frame join after the read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            err_q   <= 1'b0;
            cause_q <= CAUSE_BOUNDS;
        end else if (state_q == ST_LOOKUP && fault) begin
            paddr_q <= '0;
            err_q   <= 1'b1;
            cause_q <= cause;
        end else if (state_q == ST_WAIT) begin
            paddr_q <= {mem_rd_data[PFN_W-1:0], va_q[OFF_W-1:0]};
            err_q   <= 1'b0;
            cause_q <= CAUSE_BOUNDS;
        end
    end

    // Upper entry bits carry no meaning for translation
    logic [PTE_W-PFN_W-1:0] pte_spare_unused;
    assign pte_spare_unused = mem_rd_data[PTE_W-1:PFN_W];

    // Output decode
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        cur_seg     = va_q[VA_W-1 -: SEG_W];
        cur_page    = va_q[OFF_W +: PAGE_W];
        cur_write   = wr_q;
        mem_rd_en   = (state_q == ST_LOOKUP) && !fault;
        mem_rd_addr = pte_addr;
        rsp_valid   = (state_q == ST_RESP);
        rsp_paddr   = paddr_q;
        rsp_err     = err_q;
        rsp_cause   = cause_q;
    end

endmodule

// File: rtl/seg_xlate_top.sv
// Module: segmented paging address translator, top level.
// Connects the segment register bank, the guard and the request walker.
// Assumes: a single outstanding request and a one-cycle memory read.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 24,
    parameter int PTE_W  = 16,
    parameter int PFN_W  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEG_W-1:0]              cfg_idx,
    input  logic [PA_W-1:0]               cfg_pt_base,
    input  logic [PAGE_W-1:0]             cfg_limit,
    input  logic                          cfg_rd_ok,
    input  logic                          cfg_wr_ok,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
    input  logic                          req_is_write,
    output logic                          mem_rd_en,
    output logic [PA_W-1:0]               mem_rd_addr,
    input  logic [PTE_W-1:0]              mem_rd_data,
    output logic                          rsp_valid,
    output logic [PFN_W+OFF_W-1:0]        rsp_paddr,
    output logic                          rsp_err,
    output logic                          rsp_cause
);
    logic [SEG_W-1:0]  cur_seg;
    logic [PAGE_W-1:0] cur_page;
    logic              cur_write;
    logic [PA_W-1:0]   seg_base;
    logic [PAGE_W-1:0] seg_limit;
    logic              seg_rd_ok;
    logic              seg_wr_ok;
    logic              fault;
    xl_cause_e         cause;
    logic [PA_W-1:0]   pte_addr;

    seg_xlate_segtab #(
        .SEG_W(SEG_W), .PAGE_W(PAGE_W), .PA_W(PA_W)
    ) u_segtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_pt_base),
        .wr_limit (cfg_limit),
        .wr_rd_ok (cfg_rd_ok),
        .wr_wr_ok (cfg_wr_ok),
        .rd_idx   (cur_seg),
        .rd_base  (seg_base),
        .rd_limit (seg_limit),
        .rd_rd_ok (seg_rd_ok),
        .rd_wr_ok (seg_wr_ok)
    );

    seg_xlate_guard #(
        .PAGE_W(PAGE_W), .PA_W(PA_W), .PTE_W(PTE_W)
    ) u_guard (
        .page     (cur_page),
        .is_write (cur_write),
        .base     (seg_base),
        .limit    (seg_limit),
        .rd_ok    (seg_rd_ok),
        .wr_ok    (seg_wr_ok),
        .fault    (fault),
        .cause    (cause),
        .pte_addr (pte_addr)
    );

    seg_xlate_walker #(
        .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
        .PA_W(PA_W), .PTE_W(PTE_W), .PFN_W(PFN_W)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_is_write (req_is_write),
        .cur_seg      (cur_seg),
        .cur_page     (cur_page),
        .cur_write    (cur_write),
        .fault        (fault),
        .cause        (cause),
        .pte_addr     (pte_addr),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_err      (rsp_err),
        .rsp_cause    (rsp_cause)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
// Module: protocol and timing checker for seg_xlate_top, bound below.
// Assumes: the reset is held low for at least one clock at start-up.
module seg_xlate_chk #(
    parameter int VA_W  = 24,
    parameter int OFF_W = 12,
    parameter int PO_W  = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_rd_en,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [PO_W-1:0] rsp_paddr
);
    logic [OFF_W-1:0]      off_q;
    logic [VA_W-OFF_W-1:0] va_hi_unused;
    assign va_hi_unused = req_vaddr[VA_W-1:OFF_W];

    // Remember the offset of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
    end

    assert_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);
    // R3 and R4: a fault is never preceded by an entry read
    assert_fault_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !$past(mem_rd_en));
    assert_ok_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en)));
    assert_fault_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(req_valid && req_ready, 2));
    assert_ok_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> $past(req_valid && req_ready, 3));
    assert_fault_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_paddr == '0));
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_paddr[OFF_W-1:0] == off_q));

endmodule

bind seg_xlate_top seg_xlate_chk #(
    .VA_W(SEG_W + PAGE_W + OFF_W), .OFF_W(OFF_W), .PO_W(PFN_W + OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .mem_rd_en (mem_rd_en),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_top_tb.sv
// Bench for seg_xlate_top: directed corner cases plus seeded random traffic.
module seg_xlate_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [23:0] cfg_pt_base = '0;
    logic [7:0]  cfg_limit = '0;
    logic        cfg_rd_ok = 1'b0;
    logic        cfg_wr_ok = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        req_is_write = 1'b0;
    logic        mem_rd_en;
    logic [23:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic        rsp_err;
    logic        rsp_cause;

    int checks = 0;
    int failures = 0;
    int rd_count = 0;
    logic [23:0] rd_last = '0;

    logic [23:0] m_base [16];
    logic [7:0]  m_lim  [16];
    logic        m_r    [16];
    logic        m_w    [16];

    seg_xlate_top u_dut (.*);

    always #5 clk = ~clk;

    // Entry content as a fixed function of its address; upper bits set on purpose
    function automatic logic [15:0] pte_fn(input logic [23:0] a);
        return (a[15:0] * 16'h9E37) ^ {a[23:16], a[7:0]} ^ 16'hA000;
    endfunction

    // Memory model: one-cycle read, plus read counting
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= pte_fn(mem_rd_addr);
            rd_count = rd_count + 1;
            rd_last  <= mem_rd_addr;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [23:0] base, input logic [7:0] lim,
                       input bit r, input bit w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_pt_base = base;
        cfg_limit = lim; cfg_rd_ok = r; cfg_wr_ok = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[idx] = base; m_lim[idx] = lim; m_r[idx] = r; m_w[idx] = w;
    endtask

    logic [23:0] last_pa;

    task automatic xlate(input logic [23:0] va, input bit wr, input string tag);
        int s, pg, lat, rd0;
        bit e_err, e_cause;
        logic [23:0] e_pa, e_addr;
        s = int'(va[23:20]); pg = int'(va[19:12]);
        e_addr = m_base[s] + 24'(pg * 2);
        if (pg > int'(m_lim[s])) begin e_err = 1; e_cause = 0; e_pa = 0; end
        else if (wr ? !m_w[s] : !m_r[s]) begin e_err = 1; e_cause = 1; e_pa = 0; end
        else begin e_err = 0; e_cause = 0; e_pa = {pte_fn(e_addr)[11:0], va[11:0]}; end
        @(negedge clk);
        check(req_ready == 1'b1, "R7", "ready when idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_vaddr = va; req_is_write = wr;
        rd0 = rd_count;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7", "ready low when busy", 32'(req_ready), 0);
        lat = 1;
        while (!rsp_valid && lat < 8) begin @(negedge clk); lat++; end
        check(rsp_valid == 1'b1, tag, "response seen", 32'(rsp_valid), 1);
        check(rsp_err == e_err, tag, "fault flag", 32'(rsp_err), 32'(e_err));
        if (e_err) check(rsp_cause == e_cause, tag, "fault cause", 32'(rsp_cause), 32'(e_cause));
        check(rsp_paddr == e_pa, tag, "physical address", 32'(rsp_paddr), 32'(e_pa));
        check(lat == (e_err ? 2 : 3), "R8", "latency", 32'(lat), e_err ? 2 : 3);
        check((rd_count - rd0) == (e_err ? 0 : 1), e_err ? "R3" : "R6", "read count",
              32'(rd_count - rd0), e_err ? 0 : 1);
        if (!e_err) check(rd_last == e_addr, "R6", "entry address", 32'(rd_last), 32'(e_addr));
        last_pa = rsp_paddr;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R7", "single pulse", 32'(rsp_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] pa_a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_lim[i] = 0; m_r[i] = 0; m_w[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "reset ready", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R2", "reset rsp_valid", 32'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R2", "reset mem_rd_en", 32'(mem_rd_en), 0);
        // R2: unused segments after reset
        xlate(24'h300123, 1'b0, "R2");
        xlate(24'h305000, 1'b1, "R2");
        xlate(24'hF00FFF, 1'b1, "R2");
        // R3: limit edge
        cfg(2, 24'h001000, 8'h0F, 1, 1);
        xlate(24'h20FABC, 1'b0, "R3");
        xlate(24'h210ABC, 1'b0, "R3");
        xlate(24'h200001, 1'b1, "R1");
        // R4: permission
        cfg(0, 24'h002000, 8'hFF, 1, 0);
        xlate(24'h0FF070, 1'b1, "R4");
        xlate(24'h0FF070, 1'b0, "R1");
        cfg(5, 24'h003000, 8'h10, 0, 1);
        xlate(24'h504444, 1'b0, "R4");
        xlate(24'h504444, 1'b1, "R1");
        // R5: limit and permission both broken
        cfg(6, 24'h004000, 8'h03, 1, 0);
        xlate(24'h609123, 1'b1, "R5");
        // R9: shared table start
        cfg(8, 24'h006000, 8'h20, 1, 1);
        cfg(9, 24'h006000, 8'h20, 1, 1);
        xlate(24'h811555, 1'b0, "R9");
        pa_a = last_pa;
        xlate(24'h911555, 1'b1, "R9");
        check(pa_a == last_pa, "R9", "shared frame", 32'(last_pa), 32'(pa_a));
        // R10: reprogramming takes effect
        cfg(2, 24'h00A000, 8'h40, 1, 0);
        xlate(24'h230777, 1'b0, "R10");
        xlate(24'h230777, 1'b1, "R10");
        // R6: random tables and traffic
        for (int i = 0; i < 16; i++) begin
            if ($urandom_range(3) == 0) cfg(i, 24'h0, 8'h0, 0, 0);
            else cfg(i, 24'($urandom) & 24'hFFFFFE, 8'($urandom), 1'($urandom), 1'($urandom));
        end
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(30) == 0)
                cfg($urandom_range(15), 24'($urandom) & 24'hFFFFFE, 8'($urandom),
                    1'($urandom), 1'($urandom));
            xlate(24'($urandom), 1'($urandom), "R6");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule